// File: doc/BRIEF.md
# Two-Register Switch Calculator

This block turns a row of slide switches and five push-buttons into a small unsigned multiplier. Two buttons capture the live switch word into one of two operand registers. Three further buttons choose what the LED bank shows while they are held: the first operand, the second operand, or their product. With none of those held, the LEDs follow the switches.

Every button is brought onto the single system clock through a two-flop synchroniser. A stability counter then filters out contact bounce. The default counter length gives about 10 ms at 100 MHz. Each store action is a single-cycle pulse taken from the filtered rising edge, so no button is ever used as a clock. The LED output is twice the switch width, which holds the full product; narrower values are zero-extended.

Top module: `switch_calc`

## Requirements
- R1: A synchronous active-high reset clears both operand registers to zero, and clears the LED output to zero.
- R2: A filtered rising edge on `btn_store_a` loads the current switch word into operand A once.
- R3: A filtered rising edge on `btn_store_b` loads the current switch word into operand B once.
- R4: Holding a store button does not retrigger it. Switch changes made while the button stays held leave the operand unchanged.
- R5: A button level that lasts fewer than `DEB_CYC` consecutive clock cycles is ignored. Such a glitch on a store button loads nothing.
- R6: While `btn_show_a` is held, and is the highest-priority show button held, `led` shows operand A zero-extended. The display follows the press within `DEB_CYC`+4 cycles.
- R7: While `btn_show_b` is the only show button held, `led` shows operand B zero-extended.
- R8: While `btn_show_prod` is held, `led` shows the unsigned 2N-bit product A*B. For example, 0xFF*0xFF gives 0xFE01.
- R9: With no show button held, `led` equals the switch word zero-extended, one clock after the switches change.
- R10: When several show buttons are held, the product wins over A, and A wins over B.
- R11: The store buttons act independently of the display selection. Storing into A while A is shown updates the LEDs to the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | SW_W | Slide switch word |
| btn_store_a | input | 1 | Raw button: capture switches into A |
| btn_store_b | input | 1 | Raw button: capture switches into B |
| btn_show_a | input | 1 | Raw button: display A while held |
| btn_show_b | input | 1 | Raw button: display B while held |
| btn_show_prod | input | 1 | Raw button: display A*B while held |
| led | output | 2*SW_W | Registered LED word |

## Verification
A store button is held while the switches change underneath it. A design that stored on level rather than on edge would then show the later switch value. A three-cycle glitch on a store button must leave the operand alone; without a working debounce filter, the glitch value would be captured. All three show buttons are held together and then released one by one. A wrong priority encoder would show A or B where the product belongs. The all-ones product catches a multiplier truncated to N bits, which would show 0x01 instead of 0xFE01.

// File: rtl/switch_calc_pkg.sv
package switch_calc_pkg;

    localparam int unsigned BTN_NUM = 5;
    localparam int unsigned BI_STORE_A = 0;
    localparam int unsigned BI_STORE_B = 1;
    localparam int unsigned BI_SHOW_A  = 2;
    localparam int unsigned BI_SHOW_B  = 3;
    localparam int unsigned BI_SHOW_P  = 4;

    typedef enum logic [1:0] {
        VIEW_SW   = 2'd0,
        VIEW_B    = 2'd1,
        VIEW_A    = 2'd2,
        VIEW_PROD = 2'd3
    } view_e;

endpackage

// File: rtl/calc_btn_filter.sv
module calc_btn_filter #(
    parameter int unsigned DEB_CYC = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic level,
    output logic rise
);
    localparam int unsigned CNT_W = $clog2(DEB_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic             rise;
        logic [CNT_W-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = btn_raw;
        st_d.s2   = st_q.s1;
        st_d.rise = 1'b0;
        if (st_q.s2 == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt  = '0;
            st_d.lvl  = st_q.s2;
            st_d.rise = st_q.s2;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign level = st_q.lvl;
    assign rise  = st_q.rise;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        st_q.rise |=> !st_q.rise); // R4

    AST_LEVEL_AFTER_FULL_COUNT: assert property (@(posedge clk) disable iff (rst)
        (st_q.s2 != st_q.lvl && st_q.cnt != CNT_LAST) |=> $stable(st_q.lvl)); // R5

endmodule

// File: rtl/calc_operand_bank.sv
module calc_operand_bank #(
    parameter int unsigned SW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SW_W-1:0]   sw,
    input  logic              load_a,
    input  logic              load_b,
    output logic [SW_W-1:0]   opa,
    output logic [SW_W-1:0]   opb,
    output logic [2*SW_W-1:0] prod
);
    localparam int unsigned P_W = 2 * SW_W;

    typedef struct packed {
        logic [SW_W-1:0] a;
        logic [SW_W-1:0] b;
    } ops_t;

    ops_t ops_d, ops_q;

    always_comb begin
        ops_d = ops_q;
        if (load_a) begin
            ops_d.a = sw;
        end
        if (load_b) begin
            ops_d.b = sw;
        end
        if (rst) begin
            ops_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ops_q <= ops_d;
    end

    assign opa  = ops_q.a;
    assign opb  = ops_q.b;
    assign prod = P_W'(ops_q.a) * P_W'(ops_q.b);

    AST_A_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_a |=> ops_q.a == $past(sw)); // R2

    AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_a |=> $stable(ops_q.a)); // R4

    AST_B_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_b |=> ops_q.b == $past(sw)); // R3

    AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_b |=> $stable(ops_q.b)); // R4

endmodule

// File: rtl/calc_led_select.sv
module calc_led_select
    import switch_calc_pkg::*;
#(
    parameter int unsigned SW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SW_W-1:0]   sw,
    input  logic [SW_W-1:0]   opa,
    input  logic [SW_W-1:0]   opb,
    input  logic [2*SW_W-1:0] prod,
    input  logic              show_a,
    input  logic              show_b,
    input  logic              show_p,
    output logic [2*SW_W-1:0] led
);
    localparam int unsigned LED_W = 2 * SW_W;

    typedef struct packed {
        logic [LED_W-1:0] led;
    } disp_t;

    disp_t dp_d, dp_q;
    view_e view;

    always_comb begin
        if (show_p) begin
            view = VIEW_PROD;
        end else if (show_a) begin
            view = VIEW_A;
        end else if (show_b) begin
            view = VIEW_B;
        end else begin
            view = VIEW_SW;
        end
    end

    always_comb begin
        dp_d = dp_q;
        unique case (view)
            VIEW_PROD: dp_d.led = prod;
            VIEW_A:    dp_d.led = LED_W'(opa);
            VIEW_B:    dp_d.led = LED_W'(opb);
            default:   dp_d.led = LED_W'(sw);
        endcase
        if (rst) begin
            dp_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        dp_q <= dp_d;
    end

    assign led = dp_q.led;

    AST_IDLE_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (!show_p && !show_a && !show_b) |=> led == LED_W'($past(sw))); // R9

    AST_PROD_WINS: assert property (@(posedge clk) disable iff (rst)
        show_p |=> led == $past(prod)); // R10

    AST_A_OVER_B: assert property (@(posedge clk) disable iff (rst)
        (!show_p && show_a) |=> led == LED_W'($past(opa))); // R6

endmodule

// File: rtl/switch_calc.sv
module switch_calc
    import switch_calc_pkg::*;
#(
    parameter int unsigned SW_W    = 8,
    parameter int unsigned DEB_CYC = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SW_W-1:0]   sw,
    input  logic              btn_store_a,
    input  logic              btn_store_b,
    input  logic              btn_show_a,
    input  logic              btn_show_b,
    input  logic              btn_show_prod,
    output logic [2*SW_W-1:0] led
);
    localparam int unsigned LED_W = 2 * SW_W;

    logic [BTN_NUM-1:0] raw;
    logic [BTN_NUM-1:0] lvl;
    logic [BTN_NUM-1:0] rise;
    logic [SW_W-1:0]    opa;
    logic [SW_W-1:0]    opb;
    logic [LED_W-1:0]   prod;

    assign raw[BI_STORE_A] = btn_store_a;
    assign raw[BI_STORE_B] = btn_store_b;
    assign raw[BI_SHOW_A]  = btn_show_a;
    assign raw[BI_SHOW_B]  = btn_show_b;
    assign raw[BI_SHOW_P]  = btn_show_prod;

    for (genvar g = 0; g < BTN_NUM; g++) begin : g_btn
        calc_btn_filter #(
            .DEB_CYC (DEB_CYC)
        ) u_filt (
            .clk     (clk),
            .rst     (rst),
            .btn_raw (raw[g]),
            .level   (lvl[g]),
            .rise    (rise[g])
        );
    end

    calc_operand_bank #(
        .SW_W (SW_W)
    ) u_ops (
        .clk    (clk),
        .rst    (rst),
        .sw     (sw),
        .load_a (rise[BI_STORE_A]),
        .load_b (rise[BI_STORE_B]),
        .opa    (opa),
        .opb    (opb),
        .prod   (prod)
    );

    calc_led_select #(
        .SW_W (SW_W)
    ) u_sel (
        .clk    (clk),
        .rst    (rst),
        .sw     (sw),
        .opa    (opa),
        .opb    (opb),
        .prod   (prod),
        .show_a (lvl[BI_SHOW_A]),
        .show_b (lvl[BI_SHOW_B]),
        .show_p (lvl[BI_SHOW_P]),
        .led    (led)
    );

endmodule

// File: tb/switch_calc_test.sv
module switch_calc_test;
    localparam int CLK_PERIOD = 10;
    localparam int SW_W       = 8;
    localparam int DEB        = 16;
    localparam int SETTLE     = DEB + 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [SW_W-1:0]  sw  = '0;
    logic             st_a = 1'b0, st_b = 1'b0;
    logic             sh_a = 1'b0, sh_b = 1'b0, sh_p = 1'b0;
    logic [2*SW_W-1:0] led;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    switch_calc #(.SW_W(SW_W), .DEB_CYC(DEB)) uut (
        .clk(clk), .rst(rst), .sw(sw),
        .btn_store_a(st_a), .btn_store_b(st_b),
        .btn_show_a(sh_a), .btn_show_b(sh_b), .btn_show_prod(sh_p),
        .led(led)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] exp);
        n_chk++;
        if (led !== exp) begin
            n_fail++;
            $display("FAIL %s: led=%h expected=%h", tag, led, exp);
        end
    endtask

    task automatic tap_a(input logic [7:0] v);
        sw = v; cyc(2);
        st_a = 1'b1; cyc(SETTLE);
        st_a = 1'b0; cyc(SETTLE);
    endtask

    task automatic tap_b(input logic [7:0] v);
        sw = v; cyc(2);
        st_b = 1'b1; cyc(SETTLE);
        st_b = 1'b0; cyc(SETTLE);
    endtask

    task automatic t_reset();
        check("R1 led after reset", 16'h0000);
        sh_a = 1'b1; cyc(SETTLE);
        check("R1 A cleared", 16'h0000);
        sh_a = 1'b0; sh_b = 1'b1; cyc(SETTLE);
        check("R1 B cleared", 16'h0000);
        sh_b = 1'b0; cyc(SETTLE);
    endtask

    task automatic t_idle();
        sw = 8'h5A; cyc(2);
        check("R9 idle 5A", 16'h005A);
        sw = 8'hFF; cyc(2);
        check("R9 idle FF", 16'h00FF);
        sw = 8'h00; cyc(2);
        check("R9 idle 00", 16'h0000);
    endtask

    task automatic t_store_show();
        tap_a(8'h0C);
        tap_b(8'h0B);
        sw = 8'h33;
        sh_a = 1'b1; cyc(SETTLE);
        check("R2 R6 show A", 16'h000C);
        sh_a = 1'b0; sh_b = 1'b1; cyc(SETTLE);
        check("R3 R7 show B", 16'h000B);
        sh_b = 1'b0; sh_p = 1'b1; cyc(SETTLE);
        check("R8 product 12*11", 16'h0084);
        sh_p = 1'b0; cyc(SETTLE);
        check("R9 idle after release", 16'h0033);
    endtask

    task automatic t_hold();
        sw = 8'h21; cyc(2);
        st_a = 1'b1; cyc(SETTLE);
        sw = 8'h77; cyc(3 * DEB);
        st_a = 1'b0; cyc(SETTLE);
        sh_a = 1'b1; cyc(SETTLE);
        check("R4 held store no retrigger", 16'h0021);
        sh_a = 1'b0; cyc(SETTLE);
    endtask

    task automatic t_glitch();
        sw = 8'h99; cyc(2);
        st_a = 1'b1; cyc(3);
        st_a = 1'b0; cyc(SETTLE);
        sh_a = 1'b1; cyc(SETTLE);
        check("R5 short glitch ignored", 16'h0021);
        sh_a = 1'b0; cyc(SETTLE);
    endtask

    task automatic t_priority();
        tap_b(8'h05);
        sh_a = 1'b1; sh_b = 1'b1; sh_p = 1'b1; cyc(SETTLE);
        check("R10 product over A and B", 16'h00A5);
        sh_p = 1'b0; cyc(SETTLE);
        check("R10 A over B", 16'h0021);
        sh_a = 1'b0; cyc(SETTLE);
        check("R10 B alone", 16'h0005);
        sh_b = 1'b0; cyc(SETTLE);
    endtask

    task automatic t_store_while_show();
        sh_a = 1'b1; cyc(SETTLE);
        sw = 8'h40; cyc(2);
        st_a = 1'b1; cyc(SETTLE);
        st_a = 1'b0; cyc(4);
        check("R11 store while showing A", 16'h0040);
        sh_a = 1'b0; cyc(SETTLE);
    endtask

    task automatic t_max();
        tap_a(8'hFF);
        tap_b(8'hFF);
        sh_p = 1'b1; cyc(SETTLE);
        check("R8 full-width product", 16'hFE01);
        sh_p = 1'b0; cyc(SETTLE);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_idle();
        t_store_show();
        t_hold();
        t_glitch();
        t_priority();
        t_store_while_show();
        t_max();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
        report();
    end

endmodule